// File: doc/BRIEF.md
# Power-On Start Qualification Controller

This block decides when a power-up sequence may begin. It watches a raw on-request, a flag that says the supply is above its power-on-reset level, one "discharged" status bit per rail and three comparator outputs per temperature sensor. When all of its conditions are met, it sends the sequencer a one-cycle start pulse.

A request must be held high for a set number of clean samples before it is accepted. The controller then enters qualification. In qualification it drives the discharge enable of every rail and runs a startup-delay window. At the same time it waits for all rails to be discharged and for the temperature to fall below the release limit. The release limit depends on the warm masks and on whether qualification was entered from off or after a thermal event.

If any rail is still charged when the residual-voltage window runs out, a sticky flag is set for that rail, and the controller stays in qualification until the flags are cleared.

Top module: `pwr_start_qual`

## Requirements
- R1: While reset is held and just after it is released, start_o is 0, dsch_en_o is all zeros, rv_flag_o is all zeros and the controller is off.
- R2: A request is accepted only after on_req_i and por_ok_i have both been sampled high on DEGL_CYC consecutive rising edges. A low sample restarts the count. If everything else is ready, start_o is high after edge DEGL_CYC+START_DLY+1, where the first sampling edge is edge 1.
- R3: While por_ok_i is low, no request is accepted. Whatever the state, the edge that samples por_ok_i low sends the controller to off, and start_o and dsch_en_o are low after that edge.
- R4: dsch_en_o is all ones for every rail throughout qualification and all zeros in every other state.
- R5: In qualification, start is issued on the first edge at which all of the following hold: at least START_DLY edges have passed since entry, every dis_ok_i bit is 1 (rails unused by the sequence included), the thermal condition is met and no residual-voltage flag is set.
- R6: start_o is high for exactly one cycle. The controller is then active, with dsch_en_o low.
- R7: At qualification edge RV_TMO+1 or later, if any dis_ok_i bit is 0, rv_flag_o is set for every rail whose bit is 0. The flags are sticky, and no start is issued while any flag is set.
- R8: rv_clr_i clears all flags on the next edge. In qualification it also restarts the window, so start comes START_DLY+1 edges after the clearing edge at the earliest.
- R9: After entry from off, with at least one warm_mask_i bit at 0, the thermal condition is that every warm_hi_i bit is 0. warm_lo_i is ignored.
- R10: After entry through a thermal event, with at least one warm_mask_i bit at 0, the thermal condition is that every warm_lo_i bit is 0.
- R11: With all warm_mask_i bits at 1, the thermal condition is that every hot_lo_i bit is 0. warm_hi_i and warm_lo_i are ignored.
- R12: In the active state, therm_evt_i high moves the controller back to qualification as a thermal-event entry and restarts the window. on_req_i low, sampled without deglitch, moves it to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Raw on-request |
| por_ok_i | input | 1 | Supply above rising power-on-reset level |
| dis_ok_i | input | NR | Per rail: 1 when the rail is below the short-circuit threshold |
| warm_hi_i | input | NS | Per sensor: temperature at or above the warm rising level |
| warm_lo_i | input | NS | Per sensor: temperature at or above the warm falling level |
| hot_lo_i | input | NS | Per sensor: temperature at or above the hot falling level |
| warm_mask_i | input | NS | Per sensor: 1 masks that sensor's warm detection |
| therm_evt_i | input | 1 | Thermal shutdown event while active |
| rv_clr_i | input | 1 | Clears the residual-voltage flags |
| start_o | output | 1 | One-cycle start pulse to the sequencer |
| dsch_en_o | output | NR | Per-rail discharge enable |
| rv_flag_o | output | NR | Per-rail sticky residual-voltage flag |

## Verification
The hardest case to reach is qualification entered through a thermal event, because the only way there is through the active state. The stimulus first completes a full start and holds the request high. It then pulses therm_evt_i while only a warm-falling comparator is high. The bench checks that this comparator now blocks the start, whereas the same input pattern had not blocked a start from off. The residual-voltage timeout is reached by keeping a random subset of rails charged past the window. The bench then checks the flag pattern, clears the flags and checks that the restarted window produces a start at the predicted edge.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_QUAL = 2'd1,
    ST_ACT  = 2'd2
  } psq_state_e;
endpackage

// File: rtl/psq_deglitch.sv
module psq_deglitch #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  output logic acc_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          smp;

  assign smp = req_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!smp)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign acc_o = smp && (cnt_q == LAST);

  generate
    if (CYC > 1) begin : g_chk
      assert_accept_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_o |-> $past(smp))
        else $error("accept without a held request");
    end
  endgenerate
endmodule

// File: rtl/psq_therm_gate.sv
module psq_therm_gate #(
  parameter int NS = 4
) (
  input  logic [NS-1:0] warm_hi_i,
  input  logic [NS-1:0] warm_lo_i,
  input  logic [NS-1:0] hot_lo_i,
  input  logic [NS-1:0] mask_i,
  input  logic          from_evt_i,
  output logic          ok_o
);
  logic any_warm_live;

  assign any_warm_live = ~&mask_i;

  always_comb begin
    if (!any_warm_live)  ok_o = ~|hot_lo_i;   // R11
    else if (from_evt_i) ok_o = ~|warm_lo_i;  // R10
    else                 ok_o = ~|warm_hi_i;  // R9
  end
endmodule

// File: rtl/psq_rv_track.sv
module psq_rv_track #(
  parameter int NR = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [NR-1:0] dis_ok_i,
  output logic [NR-1:0] flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= '0;
    else if (clr_i) flag_o <= '0;
    else if (set_i) flag_o <= flag_o | ~dis_ok_i;
  end

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flag_o == '0))
    else $error("flags survive clear");

  assert_flag_only_charged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> ((flag_o & ~$past(flag_o) & $past(dis_ok_i)) == '0))
    else $error("flag set on discharged rail");
endmodule

// File: rtl/pwr_start_qual.sv
module pwr_start_qual
  import psq_pkg::*;
#(
  parameter int NR        = 8,
  parameter int NS        = 4,
  parameter int DEGL_CYC  = 16,
  parameter int START_DLY = 300,
  parameter int RV_TMO    = 4500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          on_req_i,
  input  logic          por_ok_i,
  input  logic [NR-1:0] dis_ok_i,
  input  logic [NS-1:0] warm_hi_i,
  input  logic [NS-1:0] warm_lo_i,
  input  logic [NS-1:0] hot_lo_i,
  input  logic [NS-1:0] warm_mask_i,
  input  logic          therm_evt_i,
  input  logic          rv_clr_i,
  output logic          start_o,
  output logic [NR-1:0] dsch_en_o,
  output logic [NR-1:0] rv_flag_o
);
  localparam int QW = $clog2(RV_TMO + 1);
  localparam logic [QW-1:0] Q_DLY = QW'(START_DLY);
  localparam logic [QW-1:0] Q_TMO = QW'(RV_TMO);

  psq_state_e    st_q;
  logic [QW-1:0] qcnt_q;
  logic          from_evt_q;
  logic          acc;
  logic          therm_ok;
  logic          all_dis;
  logic          go;
  logic          rv_set;

  psq_deglitch #(.CYC(DEGL_CYC)) u_degl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (on_req_i),
    .en_i  (por_ok_i),
    .acc_o (acc)
  );

  psq_therm_gate #(.NS(NS)) u_therm (
    .warm_hi_i (warm_hi_i),
    .warm_lo_i (warm_lo_i),
    .hot_lo_i  (hot_lo_i),
    .mask_i    (warm_mask_i),
    .from_evt_i(from_evt_q),
    .ok_o      (therm_ok)
  );

  psq_rv_track #(.NR(NR)) u_rv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (rv_set),
    .clr_i   (rv_clr_i),
    .dis_ok_i(dis_ok_i),
    .flag_o  (rv_flag_o)
  );

  assign all_dis = &dis_ok_i;
  assign go      = (qcnt_q >= Q_DLY) && all_dis && therm_ok && ~|rv_flag_o;
  assign rv_set  = (st_q == ST_QUAL) && por_ok_i && !rv_clr_i
                   && (qcnt_q == Q_TMO) && !all_dis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_OFF;
      qcnt_q     <= '0;
      from_evt_q <= 1'b0;
      start_o    <= 1'b0;
    end else begin
      start_o <= 1'b0;
      unique case (st_q)
        ST_OFF: begin
          if (acc) begin
            st_q       <= ST_QUAL;
            qcnt_q     <= '0;
            from_evt_q <= 1'b0;
          end
        end
        ST_QUAL: begin
          if (!por_ok_i) begin
            st_q <= ST_OFF;
          end else if (rv_clr_i) begin
            qcnt_q <= '0;
          end else if (go) begin
            st_q    <= ST_ACT;
            start_o <= 1'b1;
          end else if (qcnt_q != Q_TMO) begin
            qcnt_q <= qcnt_q + 1'b1;
          end
        end
        ST_ACT: begin
          if (!por_ok_i) begin
            st_q <= ST_OFF;
          end else if (therm_evt_i) begin
            st_q       <= ST_QUAL;
            qcnt_q     <= '0;
            from_evt_q <= 1'b1;
          end else if (!on_req_i) begin
            st_q <= ST_OFF;
          end
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign dsch_en_o = {NR{st_q == ST_QUAL}};

  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o)
    else $error("start longer than one cycle");

  assert_start_all_dis_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(all_dis))
    else $error("start with a charged rail");

  assert_start_after_dsch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(dsch_en_o == {NR{1'b1}}))
    else $error("start without discharge phase");

  assert_no_start_flagged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(rv_flag_o == '0))
    else $error("start while flagged");

  assert_por_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> (!start_o && dsch_en_o == '0))
    else $error("activity without supply");
endmodule

// File: tb/sim_pwr_start_qual.sv
`timescale 1ns/1ps
module sim_pwr_start_qual;
  localparam int NR = 6;
  localparam int NS = 3;
  localparam int D  = 4;
  localparam int S  = 20;
  localparam int T  = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          on_req = 1'b0, por_ok = 1'b0, therm_evt = 1'b0, rv_clr = 1'b0;
  logic [NR-1:0] dis_ok = '0;
  logic [NS-1:0] warm_hi = '0, warm_lo = '0, hot_lo = '0, warm_mask = '0;
  logic          start;
  logic [NR-1:0] dsch_en, rv_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_start_qual #(.NR(NR), .NS(NS), .DEGL_CYC(D), .START_DLY(S), .RV_TMO(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_req), .por_ok_i(por_ok),
    .dis_ok_i(dis_ok), .warm_hi_i(warm_hi), .warm_lo_i(warm_lo), .hot_lo_i(hot_lo),
    .warm_mask_i(warm_mask), .therm_evt_i(therm_evt), .rv_clr_i(rv_clr),
    .start_o(start), .dsch_en_o(dsch_en), .rv_flag_o(rv_flag)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic bit therm_blocks(input logic [NS-1:0] m, input logic [NS-1:0] hi,
                                      input logic [NS-1:0] lo, input logic [NS-1:0] hot,
                                      input bit from_evt);
    if (&m) return |hot;
    return from_evt ? |lo : |hi;
  endfunction

  // expected qualification edge of the start, 0 = residual-voltage timeout
  function automatic int exp_q(input int qd, input int qt, input bit blk);
    int a = (qd < 1) ? 1 : qd;
    int b = (!blk || qt < 1) ? 1 : qt;
    int r = S + 1;
    if (a > T + 1) return 0;
    if (a > r) r = a;
    if (b > r) r = b;
    return r;
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // request from off; returns edge index of start (0 = none)
  task automatic run_trial(input int qd, input int qt, input logic [NS-1:0] m,
                           input logic [NS-1:0] hi, input logic [NS-1:0] lo,
                           input logic [NS-1:0] hot, input logic [NR-1:0] dpart,
                           output int got);
    bit dsch_ok = 1'b1;
    got = 0;
    warm_mask = m;
    for (int k = 1; k <= D + T + 12; k++) begin
      on_req = 1'b1;
      dis_ok = (k - D >= qd) ? '1 : dpart;
      if (k - D >= qt) begin warm_hi = '0; warm_lo = '0; hot_lo = '0; end
      else begin warm_hi = hi; warm_lo = lo; hot_lo = hot; end
      step();
      if (start && got == 0) got = k;
      if (got == 0 && !start)
        if (dsch_en != ((k >= D) ? {NR{1'b1}} : {NR{1'b0}})) dsch_ok = 1'b0;
    end
    chk(dsch_ok, "R4 discharge enables", 0, 0);
    warm_hi = '0; warm_lo = '0; hot_lo = '0;
  endtask

  task automatic drop_req;
    on_req = 1'b0;
    step();
    chk(!start && dsch_en == '0, "R12 request drop to off", dsch_en, 0);
    step();
  endtask

  task automatic clear_and_start(input string rq);
    int got = 0;
    rv_clr = 1'b1; dis_ok = '1;
    step();
    rv_clr = 1'b0;
    chk(rv_flag == '0, "R8 flags cleared", rv_flag, 0);
    for (int k = 1; k <= S + 5; k++) begin
      step();
      if (start && got == 0) got = k;
    end
    chk(got == S + 1, rq, got, S + 1);
  endtask

  initial begin
    int got, e, qd, qt, s;
    logic [NS-1:0] m, hi, hot;
    logic [NR-1:0] dp;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk(!start && dsch_en == '0 && rv_flag == '0, "R1 in reset", {start, dsch_en}, 0);
    rst_n = 1'b1;
    step();
    chk(!start && dsch_en == '0 && rv_flag == '0, "R1 after reset", {start, dsch_en}, 0);

    // R3: request without supply is ignored
    on_req = 1'b1; dis_ok = '1;
    repeat (D + S + 5) step();
    chk(!start && dsch_en == '0, "R3 no supply no accept", dsch_en, 0);
    on_req = 1'b0; por_ok = 1'b1;
    step();

    // R2: basic latency with everything ready
    run_trial(0, 0, '0, '0, '0, '0, '1, got);
    chk(got == D + S + 1, "R2 start latency", got, D + S + 1);
    drop_req();

    // R2: glitch restarts deglitch count
    on_req = 1'b1;
    repeat (D - 1) step();
    on_req = 1'b0;
    step();
    chk(dsch_en == '0, "R2 glitch not accepted", dsch_en, 0);
    run_trial(0, 0, '0, '0, '0, '0, '1, got);
    chk(got == D + S + 1, "R2 restart after glitch", got, D + S + 1);
    drop_req();

    // R5: one unused rail late, still gates start
    run_trial(S + 9, 0, '0, '0, '0, '0, 6'b111110, got);
    chk(got == D + S + 9, "R5 unused rail gates start", got, D + S + 9);
    drop_req();

    // R9: from off, warm_lo alone does not block
    run_trial(0, T, 3'b011, '0, 3'b100, '0, '1, got);
    chk(got == D + S + 1, "R9 warm falling ignored from off", got, D + S + 1);
    // R10: thermal event entry, warm_lo now blocks
    warm_mask = 3'b000; warm_lo = 3'b010; therm_evt = 1'b1;
    step();
    therm_evt = 1'b0;
    chk(dsch_en == '1 && !start, "R12 thermal event to qualification", dsch_en, '1);
    e = 0;
    for (int k = 1; k <= S + 10; k++) begin
      step();
      if (start) e = k;
    end
    chk(e == 0, "R10 warm falling blocks after event", e, 0);
    warm_lo = '0;
    step();
    chk(start == 1'b1, "R10 release after cooling", start, 1);
    step();
    chk(!start && dsch_en == '0, "R6 single pulse then active", {start, dsch_en}, 0);
    drop_req();

    // R11: all masked, hot_lo governs, warm_hi ignored
    run_trial(0, T, 3'b111, 3'b111, 3'b111, '0, '1, got);
    chk(got == D + S + 1, "R11 masked warm ignored", got, D + S + 1);
    drop_req();
    run_trial(0, S + 15, 3'b111, '0, '0, 3'b001, '1, got);
    chk(got == D + S + 15, "R11 hot falling blocks", got, D + S + 15);
    drop_req();

    // R7/R8: timeout directed
    run_trial(T + 5, 0, '0, '0, '0, '0, 6'b101011, got);
    chk(got == 0, "R7 no start on timeout", got, 0);
    chk(rv_flag == 6'b010100, "R7 flag pattern", rv_flag, 6'b010100);
    clear_and_start("R8 restart after clear");
    drop_req();

    // R3: supply loss during qualification
    on_req = 1'b1; dis_ok = '0;
    repeat (D + 3) step();
    por_ok = 1'b0;
    step();
    chk(dsch_en == '0 && !start, "R3 supply loss in qualification", dsch_en, 0);
    por_ok = 1'b1; on_req = 1'b0;
    step();

    // random trials
    for (int i = 0; i < 24; i++) begin
      int ex;
      bit blk;
      qd  = $urandom_range(T + 8) - 2;
      qt  = $urandom_range(T) - 2;
      m   = NS'($urandom_range(7));
      s   = $urandom_range(NS - 1);
      hi  = NS'(1) << s;
      hot = $urandom_range(1) ? hi : '0;
      dp  = NR'($urandom) & ~(NR'(1) << $urandom_range(NR - 1));
      blk = therm_blocks(m, hi, hi, hot, 1'b0);
      ex  = exp_q(qd, qt, blk);
      run_trial(qd, qt, m, hi, hi, hot, dp, got);
      chk(got == ((ex == 0) ? 0 : D + ex), "R5 random start edge", got, (ex == 0) ? 0 : D + ex);
      if (ex == 0) begin
        chk(rv_flag == ~dp, "R7 random flag pattern", rv_flag, ~dp);
        clear_and_start("R8 random restart");
      end
      drop_req();
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule